// File: doc/BRIEF.md
# Ethernet Transmit Descriptor Ring Engine

This block owns the transmit side of an Ethernet controller's descriptor ring. Software places frames in a byte memory and fills a descriptor (status/control word, length, buffer pointer) for each one. Setting the Ready bit hands the descriptor to the engine. The engine polls the descriptor at its current ring index. When Ready is set, it streams the frame one byte per cycle to a MAC transmit port. Short frames are padded on request, and a CRC-32 frame check sequence is appended on request.

A simple link model reports the outcome of each attempt in the cycle that carries the last byte. A collision restarts the frame from its first byte and counts one retry. Deferral, missing heartbeat and lost carrier are recorded as flags. A late collision, an underrun or retry exhaustion is fatal. At the end the engine writes the status word back to the descriptor with Ready cleared, error flags and the retry count. It then raises an event and moves to the next ring slot. After a fatal error it stays halted until it receives a restart pulse.

Events collect in a write-1-to-clear register. Any event whose mask bit is set drives the interrupt line. The frame length must be at least 1 byte.

Top module: `eth_tx_ring`

## Requirements
- R1: After reset, `tx_valid` is 0, `evt` is 0, `irq` is 0, `halted` is 0 and `desc_idx` is 0.
- R2: A descriptor is transmitted only while status bit 15 (Ready) is set. Its bytes are read from `desc_rd_ptr` upward and sent in order, one per cycle, with `tx_last` marking the final byte.
- R3: When status bit 14 (Pad) is set and the length is below 60, bytes of value 0x88 follow the data up to a 60-byte body. Without Pad, or when the length is 60 or more, no pad bytes are sent.
- R4: When status bit 10 (CRC append) is set, the engine appends 4 FCS bytes after the body, least significant byte first. The FCS is the complement of a reflected CRC-32 (polynomial 0xEDB88320, preset 0xFFFFFFFF) over data and pad. A CRC run over body plus FCS leaves 0xDEBB20E3.
- R5: The status write-back clears bit 15 and keeps bits 14:10. It replaces bits 9:0 with: deferred bit 9, heartbeat bit 8, late collision bit 7, retry limit bit 6, retry count bits 5:2, underrun bit 1, carrier lost bit 0.
- R6: After each write-back the ring index advances by one. It returns to 0 after a descriptor with bit 13 (Wrap) set, or after slot NDESC-1.
- R7: `ln_collide` at the last byte restarts the frame from byte 0 and adds one retry. Up to 15 retries are allowed. A collision with 15 retries already used ends the frame with the retry-limit flag set and a count of 15.
- R8: `ln_defer`, `ln_no_hb` and `ln_crs_lost`, sampled at the last byte of any attempt, set the deferred, heartbeat and carrier-lost flags without stopping the engine.
- R9: After a late collision, underrun or retry-limit error, `halted` is 1 and Ready descriptors are left untouched. A `restart` pulse resumes the engine at the next ring slot.
- R10: A completion without fatal error sets event bit 1 (0x0002). A fatal completion sets bit 4 (0x0010). Writing 1s through `evt_wr`/`evt_wdata` clears the matching bits. `irq` is high while any bit of `evt & evt_mask` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_idx | output | IW | Current ring slot |
| desc_rd_status | input | 16 | Status/control word of the slot |
| desc_rd_len | input | LW | Frame length of the slot |
| desc_rd_ptr | input | AW | Buffer start address of the slot |
| desc_we | output | 1 | Status write-back strobe |
| desc_wr_status | output | 16 | Status word written back |
| buf_addr | output | AW | Buffer byte address |
| buf_data | input | 8 | Buffer byte at `buf_addr` |
| tx_valid | output | 1 | Byte valid to the MAC |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of an attempt |
| ln_collide | input | 1 | Collision on this attempt |
| ln_late | input | 1 | Late collision |
| ln_underrun | input | 1 | Underrun |
| ln_defer | input | 1 | Transmission was deferred |
| ln_no_hb | input | 1 | Heartbeat missing |
| ln_crs_lost | input | 1 | Carrier sense lost |
| restart | input | 1 | Leave the halted state |
| evt_wr | input | 1 | Event clear strobe |
| evt_wdata | input | 16 | Bits to clear |
| evt_mask | input | 16 | Interrupt mask |
| evt | output | 16 | Event register |
| irq | output | 1 | Interrupt request |
| halted | output | 1 | Stopped after a fatal error |

## Verification
The first byte appears on `tx_valid` one cycle after the clock edge at which the engine sees Ready. Later bytes follow on consecutive cycles. The status write-back, the event bit and the ring index step all take effect on the edge after the cycle with `tx_last`. The bench drives inputs and samples outputs on the falling edge. It drives the link inputs in the same falling-edge half-cycle in which it sees `tx_last`, so they are valid at the sampling edge. It checks results only after the write-back has landed in its descriptor memory, and checks cleared events one cycle after the clear strobe.

// File: rtl/eth_tx_ring.sv
module eth_tx_ring #(
  parameter int NDESC     = 8,
  parameter int AW        = 12,
  parameter int LW        = 11,
  parameter int MIN_LEN   = 60,
  parameter int RETRY_MAX = 15,
  parameter logic [7:0] PAD_BYTE = 8'h88,
  localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int PW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] desc_idx,
  input  logic [15:0]   desc_rd_status,
  input  logic [LW-1:0] desc_rd_len,
  input  logic [AW-1:0] desc_rd_ptr,
  output logic          desc_we,
  output logic [15:0]   desc_wr_status,
  output logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          ln_collide,
  input  logic          ln_late,
  input  logic          ln_underrun,
  input  logic          ln_defer,
  input  logic          ln_no_hb,
  input  logic          ln_crs_lost,
  input  logic          restart,
  input  logic          evt_wr,
  input  logic [15:0]   evt_wdata,
  input  logic [15:0]   evt_mask,
  output logic [15:0]   evt,
  output logic          irq,
  output logic          halted
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WB, S_HALT} state_t;

  state_t        state;
  logic [4:0]    d_ctl;
  logic [LW-1:0] d_len;
  logic [AW-1:0] d_ptr;
  logic [PW-1:0] pos;
  logic [3:0]    rtry;
  logic [31:0]   crc;
  logic          f_def, f_hb, f_lc, f_rl, f_un, f_csl;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic          pad_en, wrap, tc_en, in_data, in_body, fatal;
  logic [PW-1:0] body_len, frame_end, fcs_off;
  logic [31:0]   fcs;
  logic          unused_bits;

  assign pad_en    = d_ctl[4];
  assign wrap      = d_ctl[3];
  assign tc_en     = d_ctl[0];
  assign body_len  = (pad_en && {1'b0, d_len} < PW'(MIN_LEN)) ? PW'(MIN_LEN) : {1'b0, d_len};
  assign frame_end = body_len + (tc_en ? PW'(4) : PW'(0)) - PW'(1);
  assign in_data   = pos < {1'b0, d_len};
  assign in_body   = pos < body_len;
  assign fcs_off   = pos - body_len;
  assign fcs       = ~crc;
  assign fatal     = f_lc | f_rl | f_un;
  assign unused_bits = ^desc_rd_status[9:0];

  assign buf_addr  = d_ptr + AW'(pos);
  assign tx_valid  = (state == S_SEND);
  assign tx_last   = tx_valid && (pos == frame_end);
  assign tx_data   = in_data ? buf_data : in_body ? PAD_BYTE : fcs[8*fcs_off[1:0] +: 8];

  assign desc_we        = (state == S_WB);
  assign desc_wr_status = {1'b0, d_ctl, f_def, f_hb, f_lc, f_rl, rtry, f_un, f_csl};
  assign halted         = (state == S_HALT);
  assign irq            = |(evt & evt_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_idx <= '0;
      d_ctl    <= '0;
      d_len    <= '0;
      d_ptr    <= '0;
      pos      <= '0;
      rtry     <= '0;
      crc      <= '1;
      {f_def, f_hb, f_lc, f_rl, f_un, f_csl} <= '0;
    end else begin
      case (state)
        S_IDLE: if (desc_rd_status[15]) begin
          d_ctl <= desc_rd_status[14:10];
          d_len <= desc_rd_len;
          d_ptr <= desc_rd_ptr;
          pos   <= '0;
          rtry  <= '0;
          crc   <= '1;
          {f_def, f_hb, f_lc, f_rl, f_un, f_csl} <= '0;
          state <= S_SEND;
        end
        S_SEND: begin
          if (in_body) crc <= crc_step(crc, tx_data);
          if (tx_last) begin
            f_def <= f_def | ln_defer;
            f_hb  <= f_hb  | ln_no_hb;
            f_csl <= f_csl | ln_crs_lost;
            if (ln_late || ln_underrun) begin
              f_lc  <= ln_late;
              f_un  <= ln_underrun;
              state <= S_WB;
            end else if (ln_collide) begin
              if (rtry == 4'(RETRY_MAX)) begin
                f_rl  <= 1'b1;
                state <= S_WB;
              end else begin
                rtry <= rtry + 4'd1;
                pos  <= '0;
                crc  <= '1;
              end
            end else begin
              state <= S_WB;
            end
          end else begin
            pos <= pos + PW'(1);
          end
        end
        S_WB: begin
          desc_idx <= (wrap || desc_idx == IW'(NDESC - 1)) ? '0 : desc_idx + IW'(1);
          state    <= fatal ? S_HALT : S_IDLE;
        end
        default: if (restart) state <= S_IDLE;
      endcase
    end
  end

  logic [15:0] evt_set;
  assign evt_set = desc_we ? (fatal ? 16'h0010 : 16'h0002) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~(evt_wr ? evt_wdata : 16'h0)) | evt_set;
  end

  a_r5_wb_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> $past(tx_last));
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> (desc_idx == '0 || desc_idx == $past(desc_idx) + IW'(1)));
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> (halted && !tx_valid));
  a_r7_retry_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(tx_valid)) |-> rtry >= $past(rtry));
  a_r3_padded_min: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && pad_en) |-> pos >= PW'(MIN_LEN - 1));
  a_r10_evt_known_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & 16'hFFED) == 16'h0);

endmodule

// File: tb/tb_eth_tx_ring.sv
module tb_eth_tx_ring;
  localparam int NDESC = 8, AW = 12, LW = 11, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [IW-1:0] desc_idx;
  logic [15:0]   desc_rd_status, desc_wr_status, evt, evt_wdata, evt_mask;
  logic [LW-1:0] desc_rd_len;
  logic [AW-1:0] desc_rd_ptr, buf_addr;
  logic [7:0]    buf_data, tx_data;
  logic desc_we, tx_valid, tx_last, irq, halted, restart, evt_wr;
  logic ln_collide, ln_late, ln_underrun, ln_defer, ln_no_hb, ln_crs_lost;

  logic [15:0]   dstat [NDESC];
  logic [LW-1:0] dlen  [NDESC];
  logic [AW-1:0] dptr  [NDESC];
  logic [7:0]    mem   [1 << AW];
  logic h_we; logic [IW-1:0] h_idx; logic [15:0] h_val;

  assign desc_rd_status = dstat[desc_idx];
  assign desc_rd_len    = dlen[desc_idx];
  assign desc_rd_ptr    = dptr[desc_idx];
  assign buf_data       = mem[buf_addr];

  always @(posedge clk) begin
    if (desc_we) dstat[desc_idx] <= desc_wr_status;
    if (h_we)    dstat[h_idx]    <= h_val;
  end

  eth_tx_ring #(.NDESC(NDESC), .AW(AW), .LW(LW)) dut (.*);

  int checks = 0, failures = 0;
  int attempts = 0, att_base = 0, cnt = 0, last_cnt = 0, valid_seen = 0;
  logic newf = 1'b1;
  logic [7:0] cap [128];
  int cfg_ncol = 0, cfg_fatal = 0;
  logic [2:0] cfg_flags = 3'b0;

  always @(negedge clk) begin
    ln_collide = 0; ln_late = 0; ln_underrun = 0; ln_defer = 0; ln_no_hb = 0; ln_crs_lost = 0;
    if (tx_valid) begin
      valid_seen++;
      if (newf) cnt = 0;
      cap[cnt] = tx_data;
      cnt++;
      newf = tx_last;
      if (tx_last) begin
        last_cnt = cnt;
        ln_collide  = (attempts - att_base) < cfg_ncol;
        ln_late     = cfg_fatal == 1 && (attempts - att_base) == cfg_ncol;
        ln_underrun = cfg_fatal == 2 && (attempts - att_base) == cfg_ncol;
        {ln_defer, ln_no_hb, ln_crs_lost} = cfg_flags;
        attempts++;
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r; logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic host_write(input logic [IW-1:0] i, input logic [15:0] v);
    h_idx = i; h_val = v; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic wait_done(input logic [IW-1:0] i);
    while (dstat[i][15]) @(negedge clk);
  endtask

  task automatic pulse_restart();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic clear_events();
    evt_wdata = 16'hFFFF; evt_wr = 1'b1; @(negedge clk); evt_wr = 1'b0;
    check(evt == 16'h0, "R10 w1c clear", {16'h0, evt}, 32'h0);
  endtask

  // v = {fatal[1:0], flags[2:0], ncol[4:0], wrap, tc, pad, len[7:0], idx[2:0]}
  task automatic run_vec(input logic [23:0] v);
    logic [2:0] i; logic [7:0] len; logic pad, tc, wrap; int ncol, fk, body, tot, bad;
    logic [2:0] fl; logic [7:0] ex [128]; logic [31:0] c; logic [3:0] rt; logic rl, lc, un, fat;
    logic [15:0] exp_st; logic [IW-1:0] nidx;
    i = v[2:0]; len = v[10:3]; pad = v[11]; tc = v[12]; wrap = v[13];
    ncol = int'(v[18:14]); fl = v[21:19]; fk = int'(v[23:22]);
    cfg_ncol = ncol; cfg_fatal = fk; cfg_flags = fl; att_base = attempts;
    dlen[i] = LW'(len); dptr[i] = AW'(int'(i) * 256 + 16);
    host_write(i, 16'h8000 | {1'b0, pad, wrap, 2'b01, tc, 10'h155});
    wait_done(i);
    body = (pad && len < 60) ? 60 : int'(len);
    tot  = body + (tc ? 4 : 0);
    c = 32'hFFFFFFFF;
    for (int k = 0; k < body; k++) begin
      ex[k] = (k < int'(len)) ? mem[dptr[i] + AW'(k)] : 8'h88;
      c = crc_bits(c, ex[k]);
    end
    for (int k = 0; k < 4; k++) ex[body + k] = ~c[8*k +: 8];
    check(last_cnt == tot, "R2/R3/R4 frame length", last_cnt, tot);
    bad = 0;
    for (int k = 0; k < tot; k++) if (cap[k] !== ex[k]) bad++;
    check(bad == 0, "R2/R3/R4 frame bytes", bad, 0);
    if (tc) begin
      c = 32'hFFFFFFFF;
      for (int k = 0; k < tot; k++) c = crc_bits(c, cap[k]);
      check(c == 32'hDEBB20E3, "R4 residue", c, 32'hDEBB20E3);
    end
    rl = ncol >= 16; rt = rl ? 4'd15 : 4'(ncol);
    lc = fk == 1; un = fk == 2; fat = rl | lc | un;
    exp_st = {1'b0, pad, wrap, 2'b01, tc, fl[2], fl[1], lc, rl, rt, un, fl[0]};
    check(dstat[i] == exp_st, "R5/R7/R8 status write-back", {16'h0, dstat[i]}, {16'h0, exp_st});
    nidx = (wrap || i == 3'(NDESC - 1)) ? '0 : i + 3'd1;
    check(desc_idx == nidx, "R6 ring index", {29'h0, desc_idx}, {29'h0, nidx});
    check(evt == (fat ? 16'h0010 : 16'h0002), "R10 event", {16'h0, evt}, fat ? 32'h10 : 32'h2);
    check(irq == !fat, "R10 irq mask", {31'h0, irq}, {31'h0, !fat});
    check(halted == fat, "R9 halted", {31'h0, halted}, {31'h0, fat});
    if (fat) begin
      pulse_restart();
      check(!halted, "R9 restart", {31'h0, halted}, 32'h0);
    end
    clear_events();
  endtask

  localparam logic [23:0] VEC [9] = '{
    {2'd0, 3'd0, 5'd0,  1'b0, 1'b1, 1'b1, 8'd10, 3'd0},
    {2'd0, 3'd0, 5'd0,  1'b0, 1'b0, 1'b0, 8'd10, 3'd1},
    {2'd0, 3'd0, 5'd0,  1'b0, 1'b1, 1'b1, 8'd70, 3'd2},
    {2'd0, 3'd0, 5'd3,  1'b1, 1'b0, 1'b1, 8'd60, 3'd3},
    {2'd0, 3'd7, 5'd0,  1'b0, 1'b1, 1'b0, 8'd20, 3'd0},
    {2'd0, 3'd0, 5'd16, 1'b0, 1'b1, 1'b1, 8'd59, 3'd1},
    {2'd1, 3'd0, 5'd0,  1'b0, 1'b1, 1'b0, 8'd15, 3'd2},
    {2'd2, 3'd0, 5'd2,  1'b1, 1'b1, 1'b1, 8'd30, 3'd3},
    {2'd0, 3'd0, 5'd15, 1'b0, 1'b1, 1'b0, 8'd64, 3'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int vs;
    h_we = 0; h_idx = '0; h_val = '0; restart = 0; evt_wr = 0; evt_wdata = '0; evt_mask = 16'h0002;
    for (int i = 0; i < NDESC; i++) begin dstat[i] = '0; dlen[i] = '0; dptr[i] = '0; end
    for (int a = 0; a < (1 << AW); a++) mem[a] = 8'(a * 13 + 5);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid, "R1 tx_valid", {31'h0, tx_valid}, 0);
    check(evt == 0 && !irq, "R1 evt/irq", {15'h0, irq, evt}, 0);
    check(!halted && desc_idx == 0, "R1 halted/idx", {28'h0, halted, desc_idx}, 0);
    repeat (5) @(negedge clk);
    check(valid_seen == 0, "R2 idle without Ready", valid_seen, 0);

    foreach (VEC[k]) run_vec(VEC[k]);

    // R9: fatal halt ignores Ready until restart
    cfg_ncol = 0; cfg_fatal = 1; cfg_flags = 0; att_base = attempts;
    dlen[1] = 11'd12; dptr[1] = 12'h300;
    host_write(3'd1, 16'h8000);
    wait_done(3'd1);
    check(halted, "R9 late collision halts", {31'h0, halted}, 1);
    cfg_fatal = 0;
    dlen[2] = 11'd8; dptr[2] = 12'h500;
    host_write(3'd2, 16'h8000);
    vs = valid_seen;
    repeat (30) @(negedge clk);
    check(valid_seen == vs, "R9 no bytes while halted", valid_seen - vs, 0);
    check(dstat[2][15], "R9 Ready left untouched", {16'h0, dstat[2]}, 32'h8000);
    pulse_restart();
    wait_done(3'd2);
    check(last_cnt == 8 && cap[0] == mem[12'h500] && cap[7] == mem[12'h507],
          "R9 resumes at next slot", last_cnt, 8);
    check(dstat[2] == 16'h0000, "R5 plain completion status", {16'h0, dstat[2]}, 0);

    // R10: masking and selective clear
    check(evt == 16'h0012, "R10 both events", {16'h0, evt}, 32'h12);
    evt_mask = 16'h0000; @(negedge clk);
    check(!irq, "R10 mask zero", {31'h0, irq}, 0);
    evt_wdata = 16'h0010; evt_wr = 1; @(negedge clk); evt_wr = 0;
    check(evt == 16'h0002, "R10 partial w1c", {16'h0, evt}, 32'h2);
    evt_mask = 16'h0010; @(negedge clk);
    check(!irq, "R10 masked event", {31'h0, irq}, 0);
    evt_mask = 16'h0002; @(negedge clk);
    check(irq, "R10 unmasked event", {31'h0, irq}, 1);
    clear_events();

    // R6: wrap at NDESC-1 without Wrap bit
    for (int s = 3; s < NDESC; s++)
      run_vec({2'd0, 3'd0, 5'd0, 1'b0, 1'b0, 1'b0, 8'(5 + s), 3'(s)});
    check(desc_idx == 0, "R6 wrap at last slot", {29'h0, desc_idx}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule